// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block configures an SRAM-based FPGA through its serial configuration port. It acts as the master. It drives the active-low program line, the configuration clock and the serial data line, and it watches the target's init-ready and configuration-done lines. A controller starts a load by pulsing `start_i` and giving the number of bytes at the same time. The configuration bytes then come in over a valid/ready byte stream.

A load runs through a fixed sequence of phases. First the loader holds the program line low for a set number of clock cycles and then releases it. Next it polls the init-ready line until it reads high, giving up after a set number of polls. It then shifts each byte out most significant bit first, setting up the data bit before each rising clock edge. After the last byte it keeps pulsing the configuration clock until the done line reads high, giving up after a set number of extra pulses. At the end of a load the block gives a one-cycle completion pulse together with a 2-bit result code.

The program-low time, the configuration clock half-period, both timeout limits and the depth of the input synchronizer are all parameters.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the program line is high, the configuration clock and data lines are low, and `busy_o`, `s_ready_o` and `fin_o` are low.
- R2: A start request while idle drives `cfg_prog_n_o` low for exactly `PROG_LOW_CYC` system clock cycles, after which it returns high.
- R3: If the synchronized init-ready input reads low for `INIT_POLL_MAX` consecutive polls after the program line is released, the load ends with result code 1. In that case no configuration clock edge occurs and no byte is accepted.
- R4: Bytes are sent in arrival order, each one most significant bit first. The bit presented on `cfg_din_o` at each rising edge of `cfg_clk_o` is the next bit of the stream.
- R5: Exactly `byte_count_i` bytes are accepted from the stream, and the data phase produces exactly eight rising clock edges per byte.
- R6: `cfg_din_o` changes only when `cfg_clk_o` is low, both in the cycle of the change and in the cycle before it.
- R7: Every high phase of `cfg_clk_o` lasts exactly `HALF_CYC` system clock cycles.
- R8: While bytes remain and the stream has no valid byte, `cfg_clk_o` stays low and the stall does not count toward any timeout, however long it lasts.
- R9: After the last byte, clock pulses continue until the synchronized done input reads high. The load then ends with result code 0.
- R10: If done never reads high, the loader issues exactly `DONE_PULSE_MAX` extra clock pulses and then ends with result code 2.
- R11: `fin_o` is high for exactly one cycle per load, and `busy_o` is low in that cycle. A start request while busy is ignored.
- R12: A byte count of zero skips the data phase and goes straight from the init-ready wait to the done wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration load (ignored while busy) |
| byte_count_i | input | CNT_W | Number of bytes to send, sampled with start_i |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Loader accepts a byte this cycle |
| cfg_prog_n_o | output | 1 | Active-low program line to the target |
| cfg_clk_o | output | 1 | Configuration clock to the target |
| cfg_din_o | output | 1 | Serial configuration data to the target |
| cfg_init_i | input | 1 | Target init-ready line (asynchronous) |
| cfg_done_i | input | 1 | Target configuration-done line (asynchronous) |
| busy_o | output | 1 | A load is in progress |
| fin_o | output | 1 | One-cycle pulse when a load ends |
| status_o | output | 2 | Result of the last load: 0 ok, 1 init timeout, 2 done timeout |

## Verification
The embedded assertions check several properties on every cycle:
- the data line moves only while the clock is low;
- the program line is never low while the clock is high or a byte is being accepted;
- the completion pulse lasts one cycle and never overlaps busy;
- the shared timeout counter stays below its active limit;
- the bit counter never passes eight.

Other behaviours only show up at the pins across whole loads, so the bench's scenarios cover them:
- the byte order and bit order seen by the target;
- the exact number of bytes and clock pulses;
- the program-low width and the high-phase length;
- both timeout outcomes;
- immunity to long upstream stalls;
- the zero-length load.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PROG,
      ST_INIT,
      ST_FETCH,
      ST_SHIFT,
      ST_DLO,
      ST_DHI,
      ST_FLO,
      ST_FHI
   } ld_state_e;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_INIT_TO = 2'd1,
      RES_DONE_TO = 2'd2
   } ld_result_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/cfg_ld_sync.sv
module cfg_ld_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pipe_q <= '0;
            end else if (STAGES == 1) begin
               pipe_q[0] <= d_i;
            end else begin
               pipe_q <= {pipe_q[STAGES-2:0], d_i};
            end
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/cfg_ld_phase_timer.sv
module cfg_ld_phase_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         expire_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i - W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign expire_o = (cnt_q == '0);

   // R7
   timer_load_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> (load_val_i != '0));

endmodule

// File: rtl/cfg_ld_limit_ctr.sv
module cfg_ld_limit_ctr #(
   parameter int unsigned W = 17
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         inc_i,
   input  logic [W-1:0] limit_i,
   output logic         last_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   assign last_o = (cnt_q == limit_i - W'(1));

   // R10
   lim_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !clr_i) |=> (cnt_q <= $past(limit_i) - W'(1)));

endmodule

// File: rtl/cfg_ld_shifter.sv
module cfg_ld_shifter #(
   parameter int unsigned DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [DW-1:0] data_i,
   input  logic          shift_i,
   output logic          msb_o,
   output logic          drained_o
);

   localparam int unsigned BC_W = $clog2(DW + 1);

   logic [DW-1:0]   sh_q;
   logic [BC_W-1:0] bits_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '0;
         bits_q <= '0;
      end else if (load_i) begin
         sh_q   <= data_i;
         bits_q <= '0;
      end else if (shift_i) begin
         sh_q   <= {sh_q[DW-2:0], 1'b0};
         bits_q <= bits_q + BC_W'(1);
      end
   end

   assign msb_o     = sh_q[DW-1];
   assign drained_o = (bits_q == BC_W'(DW));

   // R5
   bit_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |-> (bits_q < BC_W'(DW)));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfg_ld_pkg::*;
#(
   parameter int unsigned CNT_W          = 24,
   parameter int unsigned PROG_LOW_CYC   = 64,
   parameter int unsigned HALF_CYC       = 2,
   parameter int unsigned INIT_POLL_MAX  = 100000,
   parameter int unsigned DONE_PULSE_MAX = 100000,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [CNT_W-1:0] byte_count_i,
   input  logic             s_valid_i,
   input  logic [7:0]       s_data_i,
   output logic             s_ready_o,
   output logic             cfg_prog_n_o,
   output logic             cfg_clk_o,
   output logic             cfg_din_o,
   input  logic             cfg_init_i,
   input  logic             cfg_done_i,
   output logic             busy_o,
   output logic             fin_o,
   output logic [1:0]       status_o
);

   localparam int unsigned TMR_MAX = (PROG_LOW_CYC > HALF_CYC) ? PROG_LOW_CYC : HALF_CYC;
   localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
   localparam int unsigned LIM_MAX = (INIT_POLL_MAX > DONE_PULSE_MAX) ? INIT_POLL_MAX : DONE_PULSE_MAX;
   localparam int unsigned LIM_W   = $clog2(LIM_MAX + 1);
   localparam logic [TMR_W-1:0] PROG_V = TMR_W'(PROG_LOW_CYC);
   localparam logic [TMR_W-1:0] HALF_V = TMR_W'(HALF_CYC);
   localparam logic [LIM_W-1:0] INIT_V = LIM_W'(INIT_POLL_MAX);
   localparam logic [LIM_W-1:0] DONE_V = LIM_W'(DONE_PULSE_MAX);

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (PROG_LOW_CYC < 1) begin : g_bad_prog
         $error("PROG_LOW_CYC must be at least 1");
      end
      if (INIT_POLL_MAX < 1 || DONE_PULSE_MAX < 1) begin : g_bad_lim
         $error("timeout limits must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   ld_state_e        st_q, st_n;
   logic             prog_n_q, prog_n_n;
   logic             cclk_q, cclk_n;
   logic             din_q, din_n;
   logic [CNT_W-1:0] left_q, left_n;
   logic             fin_q, fin_n;
   logic [1:0]       stat_q, stat_n;

   logic             init_s, done_s;
   logic             tmr_load, tmr_exp;
   logic [TMR_W-1:0] tmr_val;
   logic             lim_clr, lim_inc, lim_last;
   logic [LIM_W-1:0] lim_val;
   logic             sh_load, sh_shift, sh_msb, sh_drained;

   cfg_ld_sync #(.STAGES(SYNC_STAGES)) u_sync_init (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cfg_init_i), .q_o(init_s));

   cfg_ld_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cfg_done_i), .q_o(done_s));

   cfg_ld_phase_timer #(.W(TMR_W)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
      .load_val_i(tmr_val), .expire_o(tmr_exp));

   cfg_ld_limit_ctr #(.W(LIM_W)) u_limit (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(lim_clr), .inc_i(lim_inc),
      .limit_i(lim_val), .last_o(lim_last));

   cfg_ld_shifter #(.DW(BYTE_W)) u_shift (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sh_load), .data_i(s_data_i),
      .shift_i(sh_shift), .msb_o(sh_msb), .drained_o(sh_drained));

   assign lim_val = (st_q == ST_INIT) ? INIT_V : DONE_V;

   always_comb begin
      st_n     = st_q;
      prog_n_n = prog_n_q;
      cclk_n   = cclk_q;
      din_n    = din_q;
      left_n   = left_q;
      fin_n    = 1'b0;
      stat_n   = stat_q;
      tmr_load = 1'b0;
      tmr_val  = HALF_V;
      lim_clr  = 1'b0;
      lim_inc  = 1'b0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               left_n   = byte_count_i;
               prog_n_n = 1'b0;
               tmr_load = 1'b1;
               tmr_val  = PROG_V;
               st_n     = ST_PROG;
            end
         end
         ST_PROG: begin
            if (tmr_exp) begin
               prog_n_n = 1'b1;
               lim_clr  = 1'b1;
               st_n     = ST_INIT;
            end
         end
         ST_INIT: begin
            if (init_s) begin
               lim_clr = 1'b1;
               if (left_q == '0) begin
                  tmr_load = 1'b1;
                  st_n     = ST_FLO;
               end else begin
                  st_n = ST_FETCH;
               end
            end else if (lim_last) begin
               fin_n  = 1'b1;
               stat_n = RES_INIT_TO;
               st_n   = ST_IDLE;
            end else begin
               lim_inc = 1'b1;
            end
         end
         ST_FETCH: begin
            if (s_valid_i) begin
               sh_load = 1'b1;
               st_n    = ST_SHIFT;
            end
         end
         ST_SHIFT: begin
            din_n    = sh_msb;
            sh_shift = 1'b1;
            tmr_load = 1'b1;
            st_n     = ST_DLO;
         end
         ST_DLO: begin
            if (tmr_exp) begin
               cclk_n   = 1'b1;
               tmr_load = 1'b1;
               st_n     = ST_DHI;
            end
         end
         ST_DHI: begin
            if (tmr_exp) begin
               cclk_n = 1'b0;
               if (sh_drained) begin
                  left_n = left_q - CNT_W'(1);
                  if (left_q == CNT_W'(1)) begin
                     lim_clr  = 1'b1;
                     tmr_load = 1'b1;
                     st_n     = ST_FLO;
                  end else begin
                     st_n = ST_FETCH;
                  end
               end else begin
                  st_n = ST_SHIFT;
               end
            end
         end
         ST_FLO: begin
            if (done_s) begin
               fin_n  = 1'b1;
               stat_n = RES_OK;
               st_n   = ST_IDLE;
            end else if (tmr_exp) begin
               cclk_n   = 1'b1;
               tmr_load = 1'b1;
               st_n     = ST_FHI;
            end
         end
         ST_FHI: begin
            if (tmr_exp) begin
               cclk_n = 1'b0;
               if (lim_last) begin
                  fin_n  = 1'b1;
                  stat_n = RES_DONE_TO;
                  st_n   = ST_IDLE;
               end else begin
                  lim_inc  = 1'b1;
                  tmr_load = 1'b1;
                  st_n     = ST_FLO;
               end
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= ST_IDLE;
         prog_n_q <= 1'b1;
         cclk_q   <= 1'b0;
         din_q    <= 1'b0;
         left_q   <= '0;
         fin_q    <= 1'b0;
         stat_q   <= 2'd0;
      end else begin
         st_q     <= st_n;
         prog_n_q <= prog_n_n;
         cclk_q   <= cclk_n;
         din_q    <= din_n;
         left_q   <= left_n;
         fin_q    <= fin_n;
         stat_q   <= stat_n;
      end
   end

   assign s_ready_o    = (st_q == ST_FETCH);
   assign cfg_prog_n_o = prog_n_q;
   assign cfg_clk_o    = cclk_q;
   assign cfg_din_o    = din_q;
   assign busy_o       = (st_q != ST_IDLE);
   assign fin_o        = fin_q;
   assign status_o     = stat_q;

   // R6
   din_low_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cfg_din_o) |-> (!cfg_clk_o && !$past(cfg_clk_o)));

   // R2
   prog_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_prog_n_o |-> (!cfg_clk_o && !s_ready_o && busy_o));

   // R8
   stall_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_ready_o |-> (!cfg_clk_o && cfg_prog_n_o));

   // R11
   fin_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fin_o |=> !fin_o);

   // R11
   fin_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fin_o |-> (!busy_o && !cfg_clk_o));

   // R3
   init_to_no_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fin_o && status_o == 2'd1) |-> !$past(cfg_clk_o));

endmodule

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;

   localparam int CNT_W = 16;
   localparam int PLOW  = 5;
   localparam int HALF  = 2;
   localparam int IMAX  = 40;
   localparam int DMAX  = 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic             start = 1'b0;
   logic [CNT_W-1:0] count = '0;
   logic             s_valid = 1'b0;
   logic [7:0]       s_data = '0;
   logic             s_ready, prog_n, cclk, din, init_l, done_l, busy, fin;
   logic [1:0]       status;

   cfg_serial_loader #(
      .CNT_W(CNT_W), .PROG_LOW_CYC(PLOW), .HALF_CYC(HALF),
      .INIT_POLL_MAX(IMAX), .DONE_PULSE_MAX(DMAX), .SYNC_STAGES(2)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_count_i(count),
      .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
      .cfg_prog_n_o(prog_n), .cfg_clk_o(cclk), .cfg_din_o(din),
      .cfg_init_i(init_l), .cfg_done_i(done_l), .busy_o(busy),
      .fin_o(fin), .status_o(status)
   );

   int total = 0;
   int bad   = 0;

   int cur_n = 0, init_delay = -1, done_after = -1, case_id = 0;
   logic [7:0] sent [0:15];
   logic [7:0] cap  [0:15];
   logic       feed_stop = 1'b0;

   int seen_id = 0;
   int rises, prog_pulses, prog_low_cur, prog_low_len, since_rel;
   int hi_run, hi_bad, din_bad, hs, fin_cnt, fin_bad, last_status;
   logic [7:0] cap_sh;
   logic p_prog = 1'b1, p_cclk = 1'b0, p_din = 1'b0, p_fin = 1'b0;

   assign init_l = (init_delay >= 0) && (prog_pulses > 0) && prog_n && (since_rel >= init_delay);
   assign done_l = (done_after >= 0) && init_l && (rises >= 8 * cur_n + done_after);

   always @(negedge clk) begin
      if (seen_id != case_id) begin
         seen_id = case_id;
         rises = 0; prog_pulses = 0; prog_low_cur = 0; prog_low_len = 0; since_rel = 0;
         hi_run = 0; hi_bad = 0; din_bad = 0; hs = 0; fin_cnt = 0; fin_bad = 0;
         last_status = -1; cap_sh = '0;
      end
      if (!prog_n) prog_low_cur++;
      if (p_prog && !prog_n) prog_pulses++;
      if (!p_prog && prog_n) prog_low_len = prog_low_cur;
      if (prog_n && prog_pulses > 0) since_rel++;
      if (cclk && !p_cclk) begin
         rises++;
         cap_sh = {cap_sh[6:0], din};
         if (rises % 8 == 0 && rises / 8 <= cur_n && rises / 8 <= 16) cap[rises/8-1] = cap_sh;
         hi_run = 1;
      end else if (cclk) begin
         hi_run++;
      end
      if (!cclk && p_cclk && hi_run != HALF) hi_bad++;
      if (din != p_din && (cclk || p_cclk)) din_bad++;
      if (s_valid && s_ready) hs++;
      if (fin) begin
         fin_cnt++;
         last_status = int'(status);
         if (p_fin || busy) fin_bad++;
      end
      p_prog = prog_n; p_cclk = cclk; p_din = din; p_fin = fin;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_bytes(input int n, input int st);
      return (st == 1) ? 0 : n;
   endfunction

   task automatic run_case(input int n, input int idly, input int dafter, input int stall,
                           input int exp_st, input bit poke, input string tag);
      int w;
      cur_n = n; init_delay = idly; done_after = dafter;
      for (int i = 0; i < 16; i++) begin sent[i] = 8'($urandom); cap[i] = 8'h00; end
      feed_stop = 1'b0;
      case_id++;
      @(negedge clk);
      start = 1'b1; count = CNT_W'(n);
      @(negedge clk);
      start = 1'b0;
      fork
         begin : feeder
            for (int i = 0; i < n; i++) begin
               if (feed_stop) break;
               repeat ($urandom_range(0, stall)) @(negedge clk);
               s_valid = 1'b1; s_data = sent[i];
               while (!s_ready && !feed_stop) @(negedge clk);
               if (feed_stop) break;
               @(negedge clk);
               s_valid = 1'b0;
            end
            s_valid = 1'b0;
         end
         begin : poker
            if (poke) begin
               repeat (12) @(negedge clk);
               start = 1'b1; count = CNT_W'(n + 3);
               @(negedge clk);
               start = 1'b0;
            end
         end
         begin : waiter
            w = 0;
            while (fin_cnt == 0 && w < 20000) begin @(negedge clk); w++; end
            if (w >= 20000) chk(1'b0, {tag, " completion"}, 0, 1);
            feed_stop = 1'b1;
         end
      join
      repeat (3) @(negedge clk);
      chk(last_status == exp_st, {tag, " status"}, last_status, exp_st);
      // R11
      chk(fin_cnt == 1 && fin_bad == 0, "R11 fin pulse", fin_cnt * 10 + fin_bad, 10);
      chk(prog_pulses == 1, "R11 single program pulse", prog_pulses, 1);
      // R2
      chk(prog_low_len == PLOW, "R2 program low width", prog_low_len, PLOW);
      // R5
      chk(hs == exp_bytes(n, exp_st), "R5 bytes accepted", hs, exp_bytes(n, exp_st));
      if (exp_st != 1) begin
         for (int i = 0; i < n; i++)
            chk(cap[i] == sent[i], "R4 byte order msb first", int'(cap[i]), int'(sent[i]));
      end
      if (exp_st == 1) chk(rises == 0, "R3 no clock on init timeout", rises, 0);
      if (exp_st == 2) chk(rises == 8 * n + DMAX, "R10 extra pulses", rises, 8 * n + DMAX);
      if (exp_st == 0)
         chk(rises >= 8 * n + dafter && rises <= 8 * n + dafter + 3,
             {tag, " R9 pulses until done"}, rises, 8 * n + dafter);
      // R6
      chk(din_bad == 0, "R6 data moves with clock low", din_bad, 0);
      // R7
      chk(hi_bad == 0, "R7 high phase width", hi_bad, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (4) @(negedge clk);
      // R1
      chk(prog_n == 1'b1 && cclk == 1'b0 && din == 1'b0, "R1 reset pins",
          {prog_n, cclk, din}, 3'b100);
      chk(busy == 1'b0 && s_ready == 1'b0 && fin == 1'b0, "R1 reset status",
          {busy, s_ready, fin}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(prog_n == 1'b1 && busy == 1'b0, "R1 idle after reset", {prog_n, busy}, 2'b10);

      run_case(4, 3, 2, 3, 0, 1'b0, "R9 basic");
      run_case(1, 0, 0, 0, 0, 1'b0, "R9 single byte");
      run_case(0, 5, 4, 0, 0, 1'b0, "R12 zero length");
      run_case(6, -1, 2, 1, 1, 1'b0, "R3 init timeout");
      run_case(3, 2, -1, 2, 2, 1'b0, "R10 done timeout");
      run_case(5, 1, 3, 60, 0, 1'b0, "R8 long stall");
      run_case(4, 2, 1, 2, 0, 1'b1, "R11 start while busy");
      for (int k = 0; k < 6; k++)
         run_case($urandom_range(1, 10), $urandom_range(0, 20), $urandom_range(0, 10),
                  $urandom_range(0, 4), 0, 1'b0, "R4 random");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule